// File: doc/BRIEF.md
# Dual-Channel Second-Order 1-Bit Noise-Shaping Modulator

This block turns two oversampled 16-bit signed PCM channels, left and right, into two 1-bit pulse-density streams. Each channel runs its own second-order error-feedback loop. The signal passes through with unity gain, and the quantisation error is shaped by (1 - z^-1)^2. Both loops advance together on a modulator clock-enable. That enable is pulsed at 192 times the base sample rate in standard operation, and at 96 times the doubled input rate in double-speed operation.

An upstream 8x interpolator holds each sample for a group of updates: 24 updates in standard mode and 12 in double-speed mode. The block captures its input at the first update of each group and uses that captured value for the rest of the group. A small controller has three states. After reset it is in PRIME_HI. The next enable moves it to PRIME_LO (transition PRIME_HI->PRIME_LO), and the enable after that moves it to RUN (transition PRIME_LO->RUN). RUN holds until reset (transition RUN->RUN). The two priming updates emit a 1 and then a 0, which is a mid-scale pattern, while the loop state stays cleared.

Top module: `dsm2_dual`

## Requirements
- R1: While `rst` is high, and until the first enabled update after it, both bit outputs are 0. The first enabled update drives both outputs to 1 (state PRIME_HI) and the second drives both to 0 (state PRIME_LO). Loop state stays zero through these two updates, and RUN begins at the third update.
- R2: The bit outputs and all loop state change only on clock edges where `ce` is 1. Input changes made while `ce` is 0 have no effect until an enabled update.
- R3: In RUN, each enabled update computes v = xs + 2*e1 - e2, where e1 and e2 are the previous two errors and both start at 0. The output bit is 1 when v >= 0 and 0 otherwise. The new error is v - 32768 for a 1 and v + 32768 for a 0, clamped to the signed 20-bit range [-524288, 524287]. The output register shows the new bit after that same edge.
- R4: The loop input is xs = floor(3*x/4) of the signed 16-bit sample x, which keeps it within 0.75 of the feedback level 32768.
- R5: Updates in RUN are grouped. The first update of each group captures the input sample and the `dbl_speed` level. A group holds 24 updates when the captured `dbl_speed` is 0 and 12 when it is 1. Sample and speed changes inside a group have no effect on that group. The first group starts at the first RUN update.
- R6: The left and right loops have separate state and update on the same enabled edge, so each channel's stream depends only on its own input.
- R7: For a constant input held over 4096 RUN updates, the mean output (1 counted as +32768, 0 counted as -32768) lies within 1% of 32768 of xs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Modulator update enable, one pulse per update |
| dbl_speed | input | 1 | 1 selects 12-update groups, 0 selects 24-update groups |
| pcm_l | input | 16 | Left sample, two's complement |
| pcm_r | input | 16 | Right sample, two's complement |
| bit_l | output | 1 | Left 1-bit stream |
| bit_r | output | 1 | Right 1-bit stream |

## Verification
The hardest condition to reach from the ports is an input or speed change that lands strictly inside a group, because group boundaries are not visible at any output. The stimulus counts enabled updates from the end of the priming pair. It then changes the samples, and separately `dbl_speed`, at known offsets inside a group. Every update in these runs is compared against a model of the recurrence that captures the input only at group starts. Large swings between opposite-sign samples make any early capture show up within a few bits.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
    typedef enum logic [1:0] {
        ST_PRIME_HI = 2'd0,
        ST_PRIME_LO = 2'd1,
        ST_RUN      = 2'd2
    } dsm_state_t;
endpackage

// File: rtl/dsm2_ctrl.sv
module dsm2_ctrl
    import dsm2_pkg::*;
#(
    parameter int HOLD_STD = 24,
    parameter int HOLD_DBL = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic dbl_speed,
    output logic upd,
    output logic load,
    output logic force_en,
    output logic force_val
);
    localparam int HMAX = (HOLD_STD > HOLD_DBL) ? HOLD_STD : HOLD_DBL;
    localparam int PW   = (HMAX > 2) ? $clog2(HMAX) : 1;

    dsm_state_t st, nxt;
    logic [PW-1:0] phase;
    logic [PW-1:0] lim;
    logic          spd_q;
    logic          spd_now;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_PRIME_HI;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_PRIME_HI: if (ce) nxt = ST_PRIME_LO;
            ST_PRIME_LO: if (ce) nxt = ST_RUN;
            ST_RUN:      nxt = ST_RUN;
            default:     nxt = ST_PRIME_HI;
        endcase
    end

    // outputs
    always_comb begin
        upd       = 1'b0;
        force_en  = 1'b0;
        force_val = 1'b0;
        unique case (st)
            ST_PRIME_HI: begin force_en = ce; force_val = 1'b1; end
            ST_PRIME_LO: begin force_en = ce; force_val = 1'b0; end
            ST_RUN:      upd = ce;
            default:     ;
        endcase
        load = upd && (phase == '0);
    end

    always_comb begin
        spd_now = (phase == '0) ? dbl_speed : spd_q;
        lim     = spd_now ? PW'(HOLD_DBL - 1) : PW'(HOLD_STD - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            spd_q <= 1'b0;
        end else if (upd) begin
            if (phase == '0) spd_q <= dbl_speed;
            phase <= (phase == lim) ? '0 : phase + 1'b1;
        end
    end

    a_r5_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase <= PW'(HMAX - 1));
    a_r5_dbl_wrap: assert property (@(posedge clk) disable iff (rst)
        (upd && spd_q && phase == PW'(HOLD_DBL - 1) && phase != '0) |=> phase == '0);
    a_r1_run_entry: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && $past(st) != ST_RUN) |-> $past(st) == ST_PRIME_LO);
    a_r2_phase_idle: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(phase));
endmodule

// File: rtl/dsm2_loop.sv
module dsm2_loop #(
    parameter int DW      = 16,
    parameter int SW      = 20,
    parameter int FS_LOG2 = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic                 load,
    input  logic                 force_en,
    input  logic                 force_val,
    input  logic signed [DW-1:0] x_in,
    output logic                 bit_o
);
    localparam int VW = SW + 3;
    localparam logic signed [VW-1:0] FS_V    = VW'(1 << FS_LOG2);
    localparam logic signed [VW-1:0] SAT_MAX = VW'((1 << (SW - 1)) - 1);
    localparam logic signed [VW-1:0] SAT_MIN = -SAT_MAX - VW'(1);

    logic signed [SW-1:0] e1, e2, xh;
    logic signed [SW-1:0] xe, x3, xs, xcur, esat;
    logic signed [VW-1:0] v, eraw;
    logic                 q;

    always_comb begin
        xe   = SW'(x_in);
        x3   = xe + (xe <<< 1);
        xs   = x3 >>> 2;
        xcur = load ? xs : xh;
        v    = VW'(xcur) + (VW'(e1) <<< 1) - VW'(e2);
        q    = ~v[VW-1];
        eraw = q ? (v - FS_V) : (v + FS_V);
        if (eraw > SAT_MAX)      esat = SW'(SAT_MAX);
        else if (eraw < SAT_MIN) esat = SW'(SAT_MIN);
        else                     esat = SW'(eraw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e1    <= '0;
            e2    <= '0;
            xh    <= '0;
            bit_o <= 1'b0;
        end else if (force_en) begin
            bit_o <= force_val;
        end else if (upd) begin
            if (load) xh <= xs;
            e2    <= e1;
            e1    <= esat;
            bit_o <= q;
        end
    end

    a_r2_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd && !force_en) |=> $stable(bit_o));
    a_r1_force_bit: assert property (@(posedge clk) disable iff (rst)
        force_en |=> bit_o == $past(force_val));
    a_r1_prime_clear: assert property (@(posedge clk) disable iff (rst)
        force_en |=> (e1 == '0 && e2 == '0));
    a_r5_hold_sample: assert property (@(posedge clk) disable iff (rst)
        (upd && !load) |=> $stable(xh));
    a_r3_err_shift: assert property (@(posedge clk) disable iff (rst)
        upd |=> e2 == $past(e1));
endmodule

// File: rtl/dsm2_dual.sv
module dsm2_dual #(
    parameter int DW       = 16,
    parameter int SW       = 20,
    parameter int FS_LOG2  = 15,
    parameter int HOLD_STD = 24,
    parameter int HOLD_DBL = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic                 dbl_speed,
    input  logic signed [DW-1:0] pcm_l,
    input  logic signed [DW-1:0] pcm_r,
    output logic                 bit_l,
    output logic                 bit_r
);
    localparam int NCH = 2;

    logic upd, load, force_en, force_val;
    logic signed [DW-1:0] pcm [NCH];
    logic [NCH-1:0] bits;

    assign pcm[0] = pcm_l;
    assign pcm[1] = pcm_r;
    assign bit_l  = bits[0];
    assign bit_r  = bits[1];

    dsm2_ctrl #(.HOLD_STD(HOLD_STD), .HOLD_DBL(HOLD_DBL)) u_ctrl (
        .clk(clk), .rst(rst), .ce(ce), .dbl_speed(dbl_speed),
        .upd(upd), .load(load), .force_en(force_en), .force_val(force_val)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsm2_loop #(.DW(DW), .SW(SW), .FS_LOG2(FS_LOG2)) u_loop (
            .clk(clk), .rst(rst), .upd(upd), .load(load),
            .force_en(force_en), .force_val(force_val),
            .x_in(pcm[c]), .bit_o(bits[c])
        );
    end

    a_r6_lockstep_prime: assert property (@(posedge clk) disable iff (rst)
        force_en |=> bit_l == bit_r);
endmodule

// File: tb/tb_dsm2_dual.sv
module tb_dsm2_dual;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0;
    logic dbl_speed = 1'b0;
    logic signed [15:0] pcm_l = '0;
    logic signed [15:0] pcm_r = '0;
    logic bit_l, bit_r;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // model state
    int m_st, m_phase, m_spd;
    int m_e1 [2];
    int m_e2 [2];
    int m_xh [2];
    int mism;
    int ones_l, ones_r;

    always #4 clk = ~clk;

    dsm2_dual dut (
        .clk(clk), .rst(rst), .ce(ce), .dbl_speed(dbl_speed),
        .pcm_l(pcm_l), .pcm_r(pcm_r), .bit_l(bit_l), .bit_r(bit_r)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int scale(input int x);
        return (x * 3) >>> 2;
    endfunction

    task automatic model_reset();
        m_st = 0; m_phase = 0; m_spd = 0;
        for (int c = 0; c < 2; c++) begin
            m_e1[c] = 0; m_e2[c] = 0; m_xh[c] = 0;
        end
    endtask

    task automatic model_step(output bit el, output bit er);
        int xin [2];
        bit q [2];
        int lim, v, e;
        xin[0] = int'(pcm_l);
        xin[1] = int'(pcm_r);
        if (m_st == 0) begin
            q[0] = 1; q[1] = 1; m_st = 1;
        end else if (m_st == 1) begin
            q[0] = 0; q[1] = 0; m_st = 2;
        end else begin
            if (m_phase == 0) m_spd = int'(dbl_speed);
            lim = (m_spd != 0) ? 11 : 23;
            for (int c = 0; c < 2; c++) begin
                if (m_phase == 0) m_xh[c] = scale(xin[c]);
                v = m_xh[c] + 2 * m_e1[c] - m_e2[c];
                q[c] = (v >= 0);
                e = q[c] ? v - 32768 : v + 32768;
                if (e > 524287) e = 524287;
                if (e < -524288) e = -524288;
                m_e2[c] = m_e1[c];
                m_e1[c] = e;
            end
            m_phase = (m_phase == lim) ? 0 : m_phase + 1;
        end
        el = q[0];
        er = q[1];
    endtask

    // one enabled update, compared against the model
    task automatic tick();
        bit el, er;
        @(negedge clk);
        model_step(el, er);
        ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        if (bit_l !== el || bit_r !== er) mism++;
        if (bit_l === 1'b1) ones_l++;
        if (bit_r === 1'b1) ones_r++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; ce = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk(bit_l == 1'b0 && bit_r == 1'b0, "R1 reset outputs", {bit_l, bit_r}, 0);
    endtask

    task automatic t_prime();
        mism = 0;
        tick();
        chk(bit_l == 1'b1 && bit_r == 1'b1, "R1 first prime bit", {bit_l, bit_r}, 3);
        tick();
        chk(bit_l == 1'b0 && bit_r == 1'b0, "R1 second prime bit", {bit_l, bit_r}, 0);
    endtask

    task automatic t_run(input int xl, input int xr, input bit spd, input int n, input string tag);
        pcm_l = 16'(xl); pcm_r = 16'(xr); dbl_speed = spd;
        mism = 0;
        for (int i = 0; i < n; i++) tick();
        chk(mism == 0, tag, mism, 0);
    endtask

    task automatic t_gating();
        logic bl, br;
        t_reset();
        t_prime();
        t_run(9000, -7000, 1'b0, 10, "R3 run before gating");
        bl = bit_l; br = bit_r;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pcm_l = 16'(-30000 + i * 9000);
            pcm_r = 16'(25000 - i * 7000);
            dbl_speed = ~dbl_speed;
        end
        @(negedge clk);
        chk(bit_l == bl && bit_r == br, "R2 outputs still while ce low",
            {bit_l, bit_r}, {bl, br});
        t_run(9000, -7000, 1'b0, 30, "R2 state untouched by idle cycles");
    endtask

    task automatic t_mean(input int x, input bit spd);
        int d, xs;
        t_reset();
        t_prime();
        ones_l = 0; ones_r = 0;
        t_run(x, -x, spd, 4096, "R3 R4 exact stream, constant input");
        xs = scale(x);
        d = (2 * ones_l - 4096) * 8 - xs;
        chk(d <= 327 && d >= -327, "R7 left mean", 2 * ones_l - 4096, xs / 8);
        xs = scale(-x);
        d = (2 * ones_r - 4096) * 8 - xs;
        chk(d <= 327 && d >= -327, "R7 right mean", 2 * ones_r - 4096, xs / 8);
    endtask

    task automatic t_latch_std();
        t_reset();
        t_prime();
        t_run(-20000, 20000, 1'b0, 5, "R5 group start, standard");
        t_run(20000, -20000, 1'b0, 45, "R5 mid-group change ignored, standard");
    endtask

    task automatic t_latch_dbl();
        t_reset();
        t_prime();
        t_run(-22000, 15000, 1'b1, 3, "R5 group start, double speed");
        t_run(22000, -15000, 1'b1, 30, "R5 mid-group change ignored, double speed");
        t_run(22000, -15000, 1'b0, 4, "R5 speed change inside group");
        t_run(-5000, 5000, 1'b0, 40, "R5 standard groups after speed change");
    endtask

    task automatic t_channels();
        t_reset();
        t_prime();
        t_run(26000, 0, 1'b0, 60, "R6 independent channels, right idle");
        t_run(-1, 32767, 1'b1, 60, "R6 independent channels, mixed extremes");
    endtask

    initial begin
        mism = 0; ones_l = 0; ones_r = 0;
        model_reset();
        t_reset();
        t_prime();
        t_gating();
        t_latch_std();
        t_latch_dbl();
        t_channels();
        t_mean(16000, 1'b0);
        t_mean(28000, 1'b0);
        t_mean(-4000, 1'b1);
        t_mean(0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule